// File: doc/BRIEF.md
# Pipelined Address Bus Controller

This block sequences bus cycles on a processor-side local bus. For each request from the core it drives an address and a cycle-kind code, raises an address strobe for one bus state, and then waits for the external ready acknowledge. Each bus state takes two clocks, called phase one and phase two. The controller can overlap the next cycle's address with the data phase of the current cycle. The system grants this overlap one cycle at a time through a next-address input.

The next-address input counts only when it is sampled at the end of phase one. That sample is taken in a second-state (data) bus state, after the current address has been valid for a full bus state. In the same window the narrow-bus input must be low, or the sample is void. If ready arrives at the end of the first data state, the cycle ends and the next cycle starts without overlap. For this reason overlap can only begin from a cycle that has at least one wait state. After an idle state, the next cycle is always issued without overlap.

The core presents `req_valid`, `req_addr` and `req_kind` and holds them until `req_take` pulses. The controller samples requests only in the last clock of a bus state.

Top module: `pab_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it rises, `bus_state` reads 0 (idle), `addr_strobe` is low, `req_take` is low and `bus_addr`/`bus_kind` are zero.
- R2: From idle, a request present in phase two issues a cycle. `req_take` is high in that clock. From the next clock, `addr_strobe` is high for exactly two clocks in state 1 (first state), and the state then becomes 2 (data state).
- R3: Next-address is ignored in the first state. If ready is high at the end of a data state, the cycle completes. With a request pending the next state is 1, even if next-address was accepted, so zero-wait-state cycles never overlap.
- R4: At the end of a data state with ready low, next-address accepted and a request pending, the controller issues the new address in state 3 (pipelined first state). The strobe is high and `req_take` pulses.
- R5: When next-address and the narrow-bus input are both high at the end of phase one, next-address is not accepted. The controller then stays in state 2 until ready.
- R6: Once next-address has been accepted for a cycle, later samples in the same cycle have no effect. That includes an acceptance made in state 4 that carries into the following state 2.
- R7: If next-address is accepted and ready is low with no request pending, the state becomes 5 (data state, overlap granted). In state 5, a request with ready low goes to 3, ready with a request goes to 1, and ready with no request goes to 0.
- R8: In states 3 and 4, ready completes the older cycle and the state moves to 2. Without ready, state 3 moves to 4 and state 4 holds.
- R9: Leaving idle always enters state 1, never state 3.
- R10: `bus_addr` and `bus_kind` change only in the clock after `req_take`. They take the request values and otherwise hold.
- R11: `bus_state` encodes 0 idle, 1 first, 2 data, 3 pipelined first, 4 pipelined data, 5 data with overlap granted. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two per bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core has a pending cycle |
| req_addr | input | ADDR_W | Address of the pending cycle |
| req_kind | input | KIND_W | Cycle kind of the pending cycle |
| req_take | output | 1 | Pending cycle is issued in this clock |
| addr_strobe | output | 1 | New address on the bus (one bus state) |
| bus_addr | output | ADDR_W | Address driven to the bus |
| bus_kind | output | KIND_W | Cycle kind driven to the bus |
| rdy_in | input | 1 | Ready acknowledge, sampled at end of data states |
| na_in | input | 1 | Next-address grant, sampled at end of phase one |
| bs16_in | input | 1 | Narrow (16-bit) bus indication |
| bus_state | output | 3 | Current bus state code |

## Verification
The bench holds next-address high through zero-wait-state cycles. A design that let an early grant override ready would enter state 3 there when it should not. Next-address and the narrow-bus input are raised in the same window, which catches a design that ignored the narrow-bus priority and overlapped. A grant made in state 4 is followed by a low next-address in the next data state. A design that re-evaluated the grant would then fail to pipeline. The bench also returns to idle and issues again, to show that the first cycle after idle never overlaps.

// File: rtl/pab_pkg.sv
package pab_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ADDR      = 3'd1,
    ST_DATA      = 3'd2,
    ST_ADDR_PIPE = 3'd3,
    ST_DATA_PIPE = 3'd4,
    ST_DATA_HOLD = 3'd5
  } bstate_t;
endpackage

// File: rtl/pab_sample.sv
module pab_sample
  import pab_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bstate_t state,
  input  logic    na_in,
  input  logic    bs16_in,
  input  logic    clr_na,
  output logic    phase,
  output logic    na_ok
);
  logic sample_win;
  logic phase_d;
  logic na_d;

  // next address only counts once the address has lived a full bus state
  assign sample_win = !phase && (state == ST_DATA || state == ST_DATA_PIPE);

  always_comb begin
    phase_d = !phase;
    na_d    = na_ok;
    if (clr_na)
      na_d = 1'b0;
    else if (sample_win && na_in && !bs16_in)
      na_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      na_ok <= 1'b0;
    end else begin
      phase <= phase_d;
      na_ok <= na_d;
    end
  end

  AST_BS16_VETO: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && bs16_in && !na_ok) |=> !na_ok); // R5

  AST_NA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (na_ok && !phase) |=> na_ok); // R6
endmodule

// File: rtl/pab_fsm.sv
module pab_fsm
  import pab_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    phase,
  input  logic    na_ok,
  input  logic    req_valid,
  input  logic    rdy_in,
  output bstate_t state,
  output logic    issue,
  output logic    clr_na
);
  bstate_t nxt;
  bstate_t state_d;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:      nxt = req_valid ? ST_ADDR : ST_IDLE;
      ST_ADDR:      nxt = ST_DATA;
      ST_DATA: begin
        if (rdy_in)     nxt = req_valid ? ST_ADDR : ST_IDLE;
        else if (na_ok) nxt = req_valid ? ST_ADDR_PIPE : ST_DATA_HOLD;
        else            nxt = ST_DATA;
      end
      ST_DATA_HOLD: begin
        if (rdy_in) nxt = req_valid ? ST_ADDR : ST_IDLE;
        else        nxt = req_valid ? ST_ADDR_PIPE : ST_DATA_HOLD;
      end
      ST_ADDR_PIPE: nxt = rdy_in ? ST_DATA : ST_DATA_PIPE;
      ST_DATA_PIPE: nxt = rdy_in ? ST_DATA : ST_DATA_PIPE;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    state_d = phase ? nxt : state;
    issue   = phase && (nxt == ST_ADDR || nxt == ST_ADDR_PIPE);
    clr_na  = issue || (phase && rdy_in &&
              (state == ST_DATA || state == ST_DATA_HOLD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state <= ST_DATA_HOLD); // R11

  AST_STROBE_FULL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ADDR || state == ST_ADDR_PIPE) && !phase) |=> $stable(state)); // R2

  AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> (state == ST_IDLE || state == ST_ADDR)); // R9

  AST_PIPE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && state == ST_DATA && !rdy_in && na_ok && req_valid)
      |=> state == ST_ADDR_PIPE); // R4
endmodule

// File: rtl/pab_hold.sv
module pab_hold #(
  parameter int ADDR_W = 32,
  parameter int KIND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [KIND_W-1:0] kind_d,
  output logic [ADDR_W-1:0] addr_q,
  output logic [KIND_W-1:0] kind_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      kind_q <= '0;
    end else if (load) begin
      addr_q <= addr_d;
      kind_q <= kind_d;
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(addr_q) && $stable(kind_q))); // R10
endmodule

// File: rtl/pab_ctrl.sv
module pab_ctrl
  import pab_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int KIND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [KIND_W-1:0] req_kind,
  output logic              req_take,
  output logic              addr_strobe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [KIND_W-1:0] bus_kind,
  input  logic              rdy_in,
  input  logic              na_in,
  input  logic              bs16_in,
  output logic [2:0]        bus_state
);
  bstate_t state;
  logic    phase;
  logic    na_ok;
  logic    issue;
  logic    clr_na;

  pab_sample u_sample (
    .clk(clk), .rst_n(rst_n), .state(state), .na_in(na_in),
    .bs16_in(bs16_in), .clr_na(clr_na), .phase(phase), .na_ok(na_ok)
  );

  pab_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .phase(phase), .na_ok(na_ok),
    .req_valid(req_valid), .rdy_in(rdy_in), .state(state),
    .issue(issue), .clr_na(clr_na)
  );

  pab_hold #(.ADDR_W(ADDR_W), .KIND_W(KIND_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(issue), .addr_d(req_addr),
    .kind_d(req_kind), .addr_q(bus_addr), .kind_q(bus_kind)
  );

  assign req_take    = issue;
  assign addr_strobe = (state == ST_ADDR) || (state == ST_ADDR_PIPE);
  assign bus_state   = state;

  AST_TAKE_PHASE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |-> (phase && req_valid)); // R2
endmodule

// File: tb/pab_ctrl_test.sv
module pab_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, rdy_in, na_in, bs16_in;
  logic [31:0] req_addr;
  logic [2:0]  req_kind;
  logic        req_take, addr_strobe;
  logic [31:0] bus_addr;
  logic [2:0]  bus_kind;
  logic [2:0]  bus_state;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  int          m_st, m_ph;
  bit          m_fl;
  logic [31:0] m_addr;
  logic [2:0]  m_kind;

  always #10 clk = ~clk;

  pab_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_take(req_take), .addr_strobe(addr_strobe),
    .bus_addr(bus_addr), .bus_kind(bus_kind), .rdy_in(rdy_in),
    .na_in(na_in), .bs16_in(bs16_in), .bus_state(bus_state)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_next(input bit rq, input bit rd);
    case (m_st)
      0: return rq ? 1 : 0;
      1: return 2;
      2: if (rd) return rq ? 1 : 0;
         else if (m_fl) return rq ? 3 : 5;
         else return 2;
      5: if (rd) return rq ? 1 : 0;
         else return rq ? 3 : 5;
      default: return rd ? 2 : 4;
    endcase
  endfunction

  task automatic step(input bit rq, input logic [31:0] a, input logic [2:0] k,
                      input bit rd, input bit na, input bit b);
    int  nx;
    bit  iss;
    req_valid = rq; req_addr = a; req_kind = k;
    rdy_in = rd; na_in = na; bs16_in = b;
    #1;
    nx  = m_next(rq, rd);
    iss = (m_ph == 1) && (nx == 1 || nx == 3);
    chk(bus_state == 3'(m_st), "R11 state", bus_state, m_st);
    chk(addr_strobe == (m_st == 1 || m_st == 3), "R2 strobe", addr_strobe, m_st);
    chk(req_take == iss, "R2 take", req_take, iss);
    chk(bus_addr == m_addr && bus_kind == m_kind, "R10 addr", bus_addr, m_addr);
    @(posedge clk);
    if (m_ph == 0) begin
      if ((m_st == 2 || m_st == 4) && na && !b) m_fl = 1;
      m_ph = 1;
    end else begin
      if (iss) begin m_addr = a; m_kind = k; m_fl = 0; end
      else if (rd && (m_st == 2 || m_st == 5)) m_fl = 0;
      m_st = nx;
      m_ph = 0;
    end
    @(negedge clk);
  endtask

  // one bus state: next-address in phase one, ready and request in phase two
  task automatic bstate(input bit rq, input logic [31:0] a, input logic [2:0] k,
                        input bit rd, input bit na, input bit b);
    step(rq, a, k, 1'b0, na, b);
    step(rq, a, k, rd, 1'b0, 1'b0);
  endtask

  task automatic expect_state(input int exp, input string tag);
    chk(bus_state == 3'(exp), tag, bus_state, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_addr = '0; req_kind = '0;
    rdy_in = 0; na_in = 0; bs16_in = 0;
    m_st = 0; m_ph = 0; m_fl = 0; m_addr = '0; m_kind = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(bus_state == 0 && !addr_strobe && bus_addr == 0, "R1 reset", bus_state, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // idle, then zero-wait cycles with next-address held high (R3, R9)
    bstate(0, 32'h0, 3'd0, 0, 1, 0);
    expect_state(0, "R1 idle");
    bstate(1, 32'h1000, 3'd2, 0, 1, 0);
    expect_state(1, "R9 idle exit");
    bstate(1, 32'h1000, 3'd2, 0, 1, 0);
    expect_state(2, "R2 first to data");
    bstate(1, 32'h1004, 3'd3, 1, 1, 0);
    expect_state(1, "R3 zero wait no overlap");
    chk(bus_addr == 32'h1004, "R10 new addr", bus_addr, 32'h1004);
    bstate(1, 32'h1004, 3'd3, 0, 1, 0);
    bstate(1, 32'h1008, 3'd1, 1, 1, 0);
    expect_state(1, "R3 zero wait again");

    // one wait state opens overlap (R4), pipelined states (R8), sticky grant (R6)
    bstate(1, 32'h1008, 3'd1, 0, 0, 0);
    bstate(1, 32'h2000, 3'd4, 0, 1, 0);
    expect_state(3, "R4 pipelined issue");
    chk(bus_addr == 32'h2000 && addr_strobe, "R4 addr", bus_addr, 32'h2000);
    bstate(1, 32'h2004, 3'd5, 0, 0, 0);
    expect_state(4, "R8 stays pipelined");
    bstate(1, 32'h2004, 3'd5, 1, 1, 0);
    expect_state(2, "R8 older completes");
    bstate(1, 32'h2004, 3'd5, 0, 0, 0);
    expect_state(3, "R6 earlier grant kept");
    bstate(0, 32'h0, 3'd0, 1, 0, 0);
    expect_state(2, "R8 ready to data");

    // narrow bus beats next-address (R5)
    bstate(1, 32'h3000, 3'd6, 0, 1, 1);
    expect_state(2, "R5 narrow wins");
    bstate(1, 32'h3000, 3'd6, 1, 0, 0);
    expect_state(1, "R5 no overlap");

    // grant without request (R7)
    bstate(0, 32'h0, 3'd0, 0, 0, 0);
    bstate(0, 32'h0, 3'd0, 0, 1, 0);
    expect_state(5, "R7 grant no request");
    bstate(1, 32'h4000, 3'd7, 0, 0, 0);
    expect_state(3, "R7 late request overlaps");
    bstate(0, 32'h0, 3'd0, 1, 0, 0);
    bstate(0, 32'h0, 3'd0, 0, 1, 0);
    expect_state(5, "R7 grant again");
    bstate(0, 32'h0, 3'd0, 1, 0, 0);
    expect_state(0, "R7 ready to idle");

    // after idle the cycle is plain again (R9)
    bstate(1, 32'h5000, 3'd1, 0, 1, 0);
    expect_state(1, "R9 plain after idle");
    bstate(0, 32'h0, 3'd0, 0, 1, 0);
    bstate(0, 32'h0, 3'd0, 1, 0, 0);
    expect_state(0, "R3 done");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule